// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

A small processor that executes one instruction at a time over several clock states. It keeps an accumulator, an index register and a single compare flag, plus a program counter, a memory address register, a memory data register and a current instruction register. Every instruction is fetched and every operand is read or written through one memory port that carries both code and data. The memory outside the core has a synchronous read: data requested with `mem_re` in one cycle is presented on `mem_rdata` in the next.

An instruction word is 16 bits, with the opcode in bits [15:11] and an 11-bit operand (address or immediate) in bits [10:0]. The set covers immediate, direct, indirect and indexed loads, store, add and subtract, increment and decrement, compare against memory or an immediate, conditional and unconditional jumps, logical shifts, character input and output through valid/ready handshakes, halt, and return from interrupt. Between instructions the core looks at a latched interrupt request. If one is pending and interrupts are enabled, it pushes its state onto a descending stack in the same memory and jumps to a fixed service address.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low and after it is released, `halted` and `out_valid` are 0 and no memory write occurs. The first memory read after reset is at address 0. A program whose first word is opcode 0 (halt) raises `halted` on the fifth rising edge after release.
- R2: Each instruction starts with a read at the program counter, and the counter then advances by one. `mem_re` and `mem_we` are never high in the same cycle. The core samples `mem_rdata` in the cycle after `mem_re`.
- R3: Opcode 1 loads the zero-extended operand into the accumulator. Opcode 2 loads memory[operand]. Opcode 3 loads memory[memory[operand][10:0]]. Opcode 4 loads memory[operand + index[10:0]]. Opcode 5 loads the zero-extended operand into the index register.
- R4: Opcode 6 writes the accumulator to memory[operand].
- R5: Opcode 7 adds memory[operand] to the accumulator and opcode 8 subtracts it, both modulo 2^16. Opcodes 9 and 10 increment and decrement by one, modulo 2^16, the accumulator when operand bit 0 is 0 or the index register when it is 1.
- R6: Opcode 11 (compare with memory[operand]) and opcode 12 (compare with the zero-extended operand) set the flag to 1 if the accumulator is equal and to 0 otherwise. Opcode 13 jumps to the operand when the flag is 1, opcode 14 jumps when it is 0, and opcode 15 always jumps.
- R7: Opcode 16 shifts the accumulator left and opcode 17 shifts it right by operand[3:0] places. Vacated bits are filled with zeros.
- R8: Opcode 18 raises `in_ready` and stalls, with no memory access, until `in_valid` is seen. The accumulator then becomes the zero-extended `in_data`.
- R9: Opcode 19 raises `out_valid` with `out_data` equal to accumulator[7:0]. Both hold steady until `out_ready` is seen, and `out_valid` drops in the following cycle.
- R10: Opcode 0 sets `halted`. From then until reset, `halted` stays 1 and the core makes no memory access and raises no handshake.
- R11: A pulse on `irq` is latched and examined only after an instruction completes. If it is pending and interrupts are enabled, the core writes PC (the address of the next instruction), accumulator, index and flag (as bit 0) to addresses SP, SP-1, SP-2, SP-3. SP starts at 2047. The core then disables interrupts and continues at address 1024.
- R12: Opcode 20 reads back flag, index, accumulator and PC from the stack in that order, restores SP, re-enables interrupts and resumes at the restored PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 11 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_re` |
| irq | input | 1 | Interrupt request pulse |
| in_valid | input | 1 | Input character offered |
| in_ready | output | 1 | Core accepts an input character |
| in_data | input | 8 | Input character |
| out_valid | output | 1 | Output character offered |
| out_ready | input | 1 | Receiver accepts the character |
| out_data | output | 8 | Output character |
| halted | output | 1 | Core has executed halt |

## Verification
The embedded properties assume that the memory returns the addressed word exactly one cycle after each read request, that programs keep their data and code clear of the stack area near the top of memory, and that `irq` arrives only while interrupts are enabled or is simply held pending. The bench keeps to these conditions. Its memory model registers every read, each program places its variables well below the stack, and an interrupt is raised once while the main program spins in a tight loop. Handshake inputs change only on the falling clock edge, and `in_valid` is held until the core takes the character.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 5;

    typedef enum logic [OPC_W-1:0] {
        OPC_STOP    = 5'd0,
        OPC_LD_IMM  = 5'd1,
        OPC_LD_DIR  = 5'd2,
        OPC_LD_IND  = 5'd3,
        OPC_LD_IDX  = 5'd4,
        OPC_LD_IX   = 5'd5,
        OPC_ST      = 5'd6,
        OPC_ADD     = 5'd7,
        OPC_SUB     = 5'd8,
        OPC_INC     = 5'd9,
        OPC_DEC     = 5'd10,
        OPC_CMP_MEM = 5'd11,
        OPC_CMP_IMM = 5'd12,
        OPC_JMP_EQ  = 5'd13,
        OPC_JMP_NE  = 5'd14,
        OPC_JMP     = 5'd15,
        OPC_SHL     = 5'd16,
        OPC_SHR     = 5'd17,
        OPC_IN      = 5'd18,
        OPC_OUT     = 5'd19,
        OPC_RET_INT = 5'd20
    } opcode_e;

    typedef enum logic [2:0] {
        ALU_B,
        ALU_ADD,
        ALU_SUB,
        ALU_INC,
        ALU_DEC,
        ALU_SHL,
        ALU_SHR
    } alu_op_e;

    typedef enum logic [3:0] {
        S_FETCH,
        S_IREAD,
        S_ILATCH,
        S_DECODE,
        S_EXEC,
        S_OREAD,
        S_OLATCH,
        S_APPLY,
        S_CHECK,
        S_PUSH,
        S_POPA,
        S_POPR,
        S_POPW,
        S_HALT
    } state_e;

    typedef struct packed {
        logic    mem_rd;
        logic    idx;
        logic    indir;
        alu_op_e alu_op;
        logic    wr_acc;
        logic    wr_ix;
        logic    wr_flag;
        logic    a_ix;
    } dec_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output logic              eq
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0] amt;
    assign amt = b[SH_W-1:0];
    assign eq  = (a == b);

    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_INC: y = a + DATA_W'(1);
            ALU_DEC: y = a - DATA_W'(1);
            ALU_SHL: y = a << amt;
            ALU_SHR: y = a >> amt;
            default: y = b;
        endcase
    end
endmodule

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
    import acc_cpu_pkg::*;
(
    input  opcode_e opc,
    input  logic    sel_ix,
    output dec_t    dec
);
    always_comb begin
        dec = '0;
        dec.alu_op = ALU_B;
        case (opc)
            OPC_LD_IMM:  dec.wr_acc = 1'b1;
            OPC_LD_IX:   dec.wr_ix  = 1'b1;
            OPC_LD_DIR: begin
                dec.mem_rd = 1'b1;
                dec.wr_acc = 1'b1;
            end
            OPC_LD_IND: begin
                dec.mem_rd = 1'b1;
                dec.indir  = 1'b1;
                dec.wr_acc = 1'b1;
            end
            OPC_LD_IDX: begin
                dec.mem_rd = 1'b1;
                dec.idx    = 1'b1;
                dec.wr_acc = 1'b1;
            end
            OPC_ADD: begin
                dec.mem_rd = 1'b1;
                dec.alu_op = ALU_ADD;
                dec.wr_acc = 1'b1;
            end
            OPC_SUB: begin
                dec.mem_rd = 1'b1;
                dec.alu_op = ALU_SUB;
                dec.wr_acc = 1'b1;
            end
            OPC_INC, OPC_DEC: begin
                dec.alu_op = (opc == OPC_INC) ? ALU_INC : ALU_DEC;
                dec.a_ix   = sel_ix;
                dec.wr_ix  = sel_ix;
                dec.wr_acc = !sel_ix;
            end
            OPC_CMP_MEM: begin
                dec.mem_rd  = 1'b1;
                dec.wr_flag = 1'b1;
            end
            OPC_CMP_IMM: dec.wr_flag = 1'b1;
            OPC_SHL: begin
                dec.alu_op = ALU_SHL;
                dec.wr_acc = 1'b1;
            end
            OPC_SHR: begin
                dec.alu_op = ALU_SHR;
                dec.wr_acc = 1'b1;
            end
            default: dec = '0;
        endcase
    end
endmodule

// File: rtl/acc_cpu_irq.sv
module acc_cpu_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic irq,
    input  logic ack,
    output logic pending
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = (pend_q && !ack) || irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pending = pend_q;

    // R11: a request is only acknowledged when one was latched
    a_r11_ack_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> pend_q);
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 11,
    parameter int CHAR_W  = 8,
    parameter int IRQ_VEC = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_re,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              irq,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CHAR_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CHAR_W-1:0] out_data,
    output logic              halted
);
    localparam logic [ADDR_W-1:0] SP_TOP  = '1;
    localparam logic [ADDR_W-1:0] VEC_ADR = ADDR_W'(IRQ_VEC);

    typedef struct packed {
        state_e            state;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] mdr;
        logic [DATA_W-1:0] cir;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] ix;
        logic              flag;
        logic [ADDR_W-1:0] sp;
        logic              ie;
        logic [1:0]        cnt;
        logic              ind_done;
    } regs_t;

    regs_t r_d, r_q;

    opcode_e           opc;
    logic [ADDR_W-1:0] operand;
    dec_t              dec;
    logic [DATA_W-1:0] alu_a, alu_b, alu_y;
    logic              alu_eq;
    logic              irq_pend, irq_ack;

    assign opc     = opcode_e'(r_q.cir[DATA_W-1 -: OPC_W]);
    assign operand = r_q.cir[ADDR_W-1:0];

    acc_cpu_decode u_dec (
        .opc    (opc),
        .sel_ix (operand[0]),
        .dec    (dec)
    );

    assign alu_a = dec.a_ix ? r_q.ix : r_q.acc;
    assign alu_b = (r_q.state == S_APPLY) ? r_q.mdr : DATA_W'(operand);

    acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
        .op (dec.alu_op),
        .a  (alu_a),
        .b  (alu_b),
        .y  (alu_y),
        .eq (alu_eq)
    );

    acc_cpu_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq     (irq),
        .ack     (irq_ack),
        .pending (irq_pend)
    );

    always_comb begin
        r_d       = r_q;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.mar;
        mem_wdata = r_q.acc;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        irq_ack   = 1'b0;
        case (r_q.state)
            S_FETCH: begin
                r_d.mar   = r_q.pc;
                r_d.pc    = r_q.pc + 1'b1;
                r_d.state = S_IREAD;
            end
            S_IREAD: begin
                mem_re    = 1'b1;
                r_d.state = S_ILATCH;
            end
            S_ILATCH: begin
                r_d.mdr   = mem_rdata;
                r_d.state = S_DECODE;
            end
            S_DECODE: begin
                r_d.cir   = r_q.mdr;
                r_d.state = S_EXEC;
            end
            S_EXEC: begin
                r_d.state = S_CHECK;
                case (opc)
                    OPC_STOP: r_d.state = S_HALT;
                    OPC_ST: begin
                        mem_we   = 1'b1;
                        mem_addr = operand;
                    end
                    OPC_JMP:    r_d.pc = operand;
                    OPC_JMP_EQ: if (r_q.flag)  r_d.pc = operand;
                    OPC_JMP_NE: if (!r_q.flag) r_d.pc = operand;
                    OPC_IN: begin
                        in_ready = 1'b1;
                        if (in_valid) r_d.acc = DATA_W'(in_data);
                        else          r_d.state = S_EXEC;
                    end
                    OPC_OUT: begin
                        out_valid = 1'b1;
                        if (!out_ready) r_d.state = S_EXEC;
                    end
                    OPC_RET_INT: begin
                        r_d.cnt   = '0;
                        r_d.state = S_POPA;
                    end
                    default: begin
                        if (dec.mem_rd) begin
                            r_d.mar      = operand + (dec.idx ? r_q.ix[ADDR_W-1:0] : '0);
                            r_d.ind_done = 1'b0;
                            r_d.state    = S_OREAD;
                        end else begin
                            if (dec.wr_acc)  r_d.acc  = alu_y;
                            if (dec.wr_ix)   r_d.ix   = alu_y;
                            if (dec.wr_flag) r_d.flag = alu_eq;
                        end
                    end
                endcase
            end
            S_OREAD: begin
                mem_re    = 1'b1;
                r_d.state = S_OLATCH;
            end
            S_OLATCH: begin
                r_d.mdr   = mem_rdata;
                r_d.state = S_APPLY;
            end
            S_APPLY: begin
                if (dec.indir && !r_q.ind_done) begin
                    r_d.mar      = r_q.mdr[ADDR_W-1:0];
                    r_d.ind_done = 1'b1;
                    r_d.state    = S_OREAD;
                end else begin
                    if (dec.wr_acc)  r_d.acc  = alu_y;
                    if (dec.wr_flag) r_d.flag = alu_eq;
                    r_d.state = S_CHECK;
                end
            end
            S_CHECK: begin
                r_d.cnt   = '0;
                r_d.state = (irq_pend && r_q.ie) ? S_PUSH : S_FETCH;
            end
            S_PUSH: begin
                mem_we   = 1'b1;
                mem_addr = r_q.sp;
                case (r_q.cnt)
                    2'd0:    mem_wdata = DATA_W'(r_q.pc);
                    2'd1:    mem_wdata = r_q.acc;
                    2'd2:    mem_wdata = r_q.ix;
                    default: mem_wdata = DATA_W'(r_q.flag);
                endcase
                r_d.sp  = r_q.sp - 1'b1;
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == 2'd3) begin
                    r_d.pc    = VEC_ADR;
                    r_d.ie    = 1'b0;
                    irq_ack   = 1'b1;
                    r_d.state = S_FETCH;
                end
            end
            S_POPA: begin
                r_d.sp    = r_q.sp + 1'b1;
                r_d.state = S_POPR;
            end
            S_POPR: begin
                mem_re    = 1'b1;
                mem_addr  = r_q.sp;
                r_d.state = S_POPW;
            end
            S_POPW: begin
                case (r_q.cnt)
                    2'd0:    r_d.flag = mem_rdata[0];
                    2'd1:    r_d.ix   = mem_rdata;
                    2'd2:    r_d.acc  = mem_rdata;
                    default: r_d.pc   = mem_rdata[ADDR_W-1:0];
                endcase
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == 2'd3) begin
                    r_d.ie    = 1'b1;
                    r_d.state = S_CHECK;
                end else begin
                    r_d.state = S_POPA;
                end
            end
            default: r_d.state = S_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_FETCH;
            r_q.sp    <= SP_TOP;
            r_q.ie    <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_data = r_q.acc[CHAR_W-1:0];
    assign halted   = (r_q.state == S_HALT);

    // R2: one port, never read and write together
    a_r2_no_rw_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R2: the fetch step advances the program counter by one
    a_r2_fetch_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_FETCH) |=> (r_q.pc == $past(r_q.pc) + 1'b1));

    // R9: an offered character stays put until taken
    a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10: halt is sticky and silent
    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    a_r10_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_re && !mem_we && !in_ready && !out_valid));

    // R11: stacking begins only at an instruction boundary
    a_r11_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.state == S_PUSH) |-> ($past(r_q.state) == S_CHECK));

    // R12: a restored frame leaves interrupts enabled
    a_r12_ie_back: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_POPW && r_q.cnt == 2'd3) |=> r_q.ie);
endmodule

// File: tb/acc_cpu_bench.sv
`timescale 1ns/1ps
module acc_cpu_bench;
    localparam int OP_STOP = 0, OP_LDM = 1, OP_LDD = 2, OP_LDI = 3, OP_LDX = 4,
                   OP_LDR = 5, OP_STO = 6, OP_ADD = 7, OP_SUB = 8, OP_INC = 9,
                   OP_DEC = 10, OP_CMP = 11, OP_CMPI = 12, OP_JEQ = 13,
                   OP_JNE = 14, OP_JMP = 15, OP_SHL = 16, OP_SHR = 17,
                   OP_IN = 18, OP_OUT = 19, OP_RTI = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_re, mem_we;
    logic [10:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        irq = 1'b0;
    logic        in_valid = 1'b0, in_ready;
    logic [7:0]  in_data = 8'h00;
    logic        out_valid, out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        halted;

    int errors = 0;
    int checks = 0;

    logic [15:0] mem [0:2047];
    logic [15:0] rd_q;
    logic        seen_rd;
    logic [10:0] first_rd;
    logic        seen_we;
    int          acc_cnt;

    always #4 clk = ~clk;

    acc_cpu u_acc_cpu (
        .clk(clk), .rst_n(rst_n), .mem_re(mem_re), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .irq(irq), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .halted(halted)
    );

    assign mem_rdata = rd_q;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) rd_q <= mem[mem_addr];
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_rd <= 1'b0;
            first_rd <= '0;
            seen_we <= 1'b0;
            acc_cnt <= 0;
        end else begin
            if (mem_re && !seen_rd) begin
                seen_rd  <= 1'b1;
                first_rd <= mem_addr;
            end
            if (mem_we) seen_we <= 1'b1;
            if (halted && (mem_re || mem_we)) acc_cnt <= acc_cnt + 1;
        end
    end

    function automatic logic [15:0] enc(input int op, input int opnd);
        logic [4:0]  o = op[4:0];
        logic [10:0] a = opnd[10:0];
        return {o, a};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic prep();
        @(negedge clk);
        rst_n = 1'b0;
        irq = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
    endtask

    task automatic go();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_halt(input string tag);
        int n = 0;
        while (!halted && n < 4000) begin
            @(negedge clk);
            n++;
        end
        check({tag, " halt reached"}, int'(halted), 1);
    endtask

    task automatic t_reset();
        prep();
        mem[0] = enc(OP_STOP, 0);
        @(negedge clk);
        check("R1 halted in reset", int'(halted), 0);
        check("R1 out_valid in reset", int'(out_valid), 0);
        go();
        repeat (4) @(negedge clk);
        check("R1 not halted after 4 edges", int'(halted), 0);
        @(negedge clk);
        check("R1 halted after 5 edges", int'(halted), 1);
        check("R1 first read address", int'(first_rd), 0);
        check("R1 no write", int'(seen_we), 0);
    endtask

    task automatic t_loads();
        prep();
        mem[0] = enc(OP_LDM, 5);     mem[1] = enc(OP_STO, 200);
        mem[2] = enc(OP_LDD, 300);   mem[3] = enc(OP_STO, 201);
        mem[4] = enc(OP_LDI, 301);   mem[5] = enc(OP_STO, 202);
        mem[6] = enc(OP_LDR, 3);     mem[7] = enc(OP_LDX, 300);
        mem[8] = enc(OP_STO, 203);   mem[9] = enc(OP_STOP, 0);
        mem[300] = 16'h1234; mem[301] = 16'h012E; mem[302] = 16'hBEEF;
        mem[303] = 16'h5555;
        go();
        wait_halt("R3");
        check("R3 immediate load / R4 store", int'(mem[200]), 16'h0005);
        check("R3 direct load", int'(mem[201]), 16'h1234);
        check("R3 indirect load", int'(mem[202]), 16'hBEEF);
        check("R3 indexed load", int'(mem[203]), 16'h5555);
    endtask

    task automatic t_arith();
        prep();
        mem[0]  = enc(OP_LDD, 310);  mem[1]  = enc(OP_ADD, 311);
        mem[2]  = enc(OP_STO, 210);  mem[3]  = enc(OP_SUB, 311);
        mem[4]  = enc(OP_STO, 211);  mem[5]  = enc(OP_INC, 0);
        mem[6]  = enc(OP_STO, 212);  mem[7]  = enc(OP_DEC, 0);
        mem[8]  = enc(OP_STO, 213);  mem[9]  = enc(OP_LDR, 7);
        mem[10] = enc(OP_INC, 1);    mem[11] = enc(OP_DEC, 1);
        mem[12] = enc(OP_DEC, 1);    mem[13] = enc(OP_LDX, 320);
        mem[14] = enc(OP_STO, 214);  mem[15] = enc(OP_STOP, 0);
        mem[310] = 16'hFFFF; mem[311] = 16'h0002; mem[326] = 16'hA5A5;
        go();
        wait_halt("R5");
        check("R5 add wraps", int'(mem[210]), 16'h0001);
        check("R5 subtract wraps", int'(mem[211]), 16'hFFFF);
        check("R5 increment acc wraps", int'(mem[212]), 16'h0000);
        check("R5 decrement acc wraps", int'(mem[213]), 16'hFFFF);
        check("R5 index inc/dec", int'(mem[214]), 16'hA5A5);
    endtask

    task automatic t_cmpjump();
        prep();
        mem[0]  = enc(OP_LDM, 9);    mem[1]  = enc(OP_CMPI, 9);
        mem[2]  = enc(OP_JEQ, 4);    mem[3]  = enc(OP_STO, 220);
        mem[4]  = enc(OP_CMPI, 8);   mem[5]  = enc(OP_JEQ, 9);
        mem[6]  = enc(OP_LDM, 1);    mem[7]  = enc(OP_STO, 221);
        mem[8]  = enc(OP_JNE, 10);   mem[9]  = enc(OP_STO, 222);
        mem[10] = enc(OP_CMP, 330);  mem[11] = enc(OP_JNE, 15);
        mem[12] = enc(OP_LDM, 16'h77); mem[13] = enc(OP_STO, 223);
        mem[14] = enc(OP_JMP, 16);   mem[15] = enc(OP_STO, 224);
        mem[16] = enc(OP_STOP, 0);
        mem[330] = 16'h0001;
        go();
        wait_halt("R6");
        check("R6 equal taken", int'(mem[220]), 0);
        check("R6 unequal not taken", int'(mem[221]), 1);
        check("R6 not-equal taken", int'(mem[222]), 0);
        check("R6 memory compare", int'(mem[223]), 16'h0077);
        check("R6 unconditional jump", int'(mem[224]), 0);
    endtask

    task automatic t_shift();
        prep();
        mem[0] = enc(OP_LDD, 340);   mem[1] = enc(OP_SHL, 4);
        mem[2] = enc(OP_STO, 230);   mem[3] = enc(OP_LDD, 340);
        mem[4] = enc(OP_SHR, 15);    mem[5] = enc(OP_STO, 231);
        mem[6] = enc(OP_LDD, 341);   mem[7] = enc(OP_SHR, 4);
        mem[8] = enc(OP_STO, 232);   mem[9] = enc(OP_STOP, 0);
        mem[340] = 16'h8001; mem[341] = 16'hF0F0;
        go();
        wait_halt("R7");
        check("R7 left shift zero fill", int'(mem[230]), 16'h0010);
        check("R7 right shift by 15", int'(mem[231]), 16'h0001);
        check("R7 right shift zero fill", int'(mem[232]), 16'h0F0F);
    endtask

    task automatic t_io();
        int n;
        prep();
        mem[0] = enc(OP_IN, 0);      mem[1] = enc(OP_STO, 21);
        mem[2] = enc(OP_ADD, 20);    mem[3] = enc(OP_OUT, 0);
        mem[4] = enc(OP_STOP, 0);
        mem[20] = 16'h0001;
        go();
        repeat (12) @(negedge clk);
        check("R8 stalled with in_ready", int'(in_ready), 1);
        check("R8 stall has no access", int'(mem_re | mem_we), 0);
        in_data = 8'h41;
        in_valid = 1'b1;
        n = 0;
        while (!in_ready && n < 100) begin @(negedge clk); n++; end
        @(negedge clk);
        in_valid = 1'b0;
        n = 0;
        while (!out_valid && n < 200) begin @(negedge clk); n++; end
        check("R9 out_valid raised", int'(out_valid), 1);
        check("R9 out_data", int'(out_data), 16'h42);
        repeat (5) @(negedge clk);
        check("R9 out_valid held", int'(out_valid), 1);
        check("R9 out_data held", int'(out_data), 16'h42);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R9 out_valid dropped", int'(out_valid), 0);
        wait_halt("R9");
        check("R8 input zero-extended", int'(mem[21]), 16'h0041);
    endtask

    task automatic t_halt();
        repeat (40) @(negedge clk);
        check("R10 halted sticky", int'(halted), 1);
        check("R10 no access after halt", acc_cnt, 0);
        check("R10 no handshake", int'(in_ready | out_valid), 0);
    endtask

    task automatic t_irq();
        prep();
        mem[0] = enc(OP_LDR, 5);     mem[1] = enc(OP_LDM, 3);
        mem[2] = enc(OP_CMPI, 3);    mem[3] = enc(OP_JMP, 3);
        mem[4] = enc(OP_STO, 243);   mem[5] = enc(OP_LDX, 370);
        mem[6] = enc(OP_STO, 244);   mem[7] = enc(OP_JEQ, 9);
        mem[8] = enc(OP_STO, 245);   mem[9] = enc(OP_STOP, 0);
        mem[375] = 16'h003C;
        mem[1024] = enc(OP_LDD, 2047); mem[1025] = enc(OP_STO, 246);
        mem[1026] = enc(OP_LDD, 2046); mem[1027] = enc(OP_STO, 240);
        mem[1028] = enc(OP_LDD, 2045); mem[1029] = enc(OP_STO, 241);
        mem[1030] = enc(OP_LDD, 2044); mem[1031] = enc(OP_STO, 242);
        mem[1032] = enc(OP_LDM, 4);    mem[1033] = enc(OP_STO, 2047);
        mem[1034] = enc(OP_LDM, 16'h66); mem[1035] = enc(OP_LDR, 0);
        mem[1036] = enc(OP_CMPI, 0);   mem[1037] = enc(OP_RTI, 0);
        go();
        repeat (80) @(negedge clk);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        wait_halt("R11");
        check("R11 pushed PC of next instruction", int'(mem[246]), 3);
        check("R11 pushed accumulator", int'(mem[240]), 3);
        check("R11 pushed index", int'(mem[241]), 5);
        check("R11 pushed flag", int'(mem[242]), 1);
        check("R12 accumulator restored", int'(mem[243]), 3);
        check("R12 index restored", int'(mem[244]), 16'h003C);
        check("R12 flag restored", int'(mem[245]), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_loads();
        t_arith();
        t_cmpjump();
        t_shift();
        t_io();
        t_halt();
        t_irq();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule